// File: doc/BRIEF.md
# Descriptor Ring DMA Sequencer

This block walks a chain of buffer descriptors in memory on behalf of one DMA channel. It is given a base address and a start pulse. It then reads each descriptor through a single-word memory port and splits the first word into a byte count, a status byte and a command byte. It hands the described buffer to a datapath as a transfer request. When the datapath reports completion, the block writes the updated first word back to memory and moves its current-descriptor pointer on. The pointer either advances past the descriptor or, on a wrap mark, returns to the base.

A descriptor is eight bytes long, or twelve bytes when its extended mark is set; the third word then carries an extended buffer address. The status byte of each descriptor says whether the host still hands it to the engine, whether more descriptors follow, and whether an interrupt is wanted. The engine clears the handover mark when it is done with a descriptor and flags failed transfers in it. A descriptor that reaches the engine without the handover mark stops the walk. The data movement itself belongs to the datapath and is not part of this block.

Top module: `bdring_seq`

## Requirements
- R1: After reset, busy, irq and err_flag are 0 and cur_ptr is 0. A start pulse while idle copies base_ptr into cur_ptr and raises busy on the next cycle. A start pulse while busy has no effect.
- R2: Descriptor word 0 is read at cur_ptr, with count in bits [15:0], status in bits [23:16] and command in bits [31:24]. Word 1, the buffer address, is read at cur_ptr+4. Word 2 is read at cur_ptr+8 only when status bit 7 (extended) is set.
- R3: The transfer request presents word 1 as xfer_addr and word 2 as xfer_ext_addr (0 for an 8-byte descriptor). It also presents the count, command bits [1:0] as xfer_size (0 = 32-bit, 1 = 8-bit, 2 = 16-bit, 3 = 24-bit) and command bit 7 as xfer_swap. The request stays high and stable until xfer_done, and never overlaps a memory access.
- R4: If status bit 0 (owned) is clear when word 0 is fetched, no transfer and no write take place. busy falls, and cur_ptr keeps that descriptor's address.
- R5: After the transfer, word 0 is written back to cur_ptr with status bit 0 cleared and status bit 4 set if xfer_err came with xfer_done. Every other bit is left unchanged.
- R6: After write-back, cur_ptr becomes the latched base address if status bit 1 (wrap) is set. Otherwise it becomes cur_ptr+12 for an extended descriptor or cur_ptr+8 for a plain one.
- R7: If status bit 2 (continue) is set, the next descriptor is fetched from the new cur_ptr. Otherwise busy falls after the pointer update.
- R8: irq is a one-cycle pulse, issued when the write-back of a descriptor with status bit 3 set completes.
- R9: err_flag rises with the write-back of a failed descriptor. It stays high through later descriptors and idle time, and is cleared only by an accepted start.
- R10: A failed transfer does not end the walk; continue and wrap are followed as for a good one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| base_ptr | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request to the datapath |
| xfer_addr | output | 32 | Buffer address |
| xfer_ext_addr | output | 32 | Extended buffer address |
| xfer_count | output | 16 | Byte count |
| xfer_size | output | 2 | Element size code |
| xfer_swap | output | 1 | Byte order swap request |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer failed, valid with xfer_done |
| cur_ptr | output | AW | Current descriptor address |
| busy | output | 1 | Channel is walking descriptors |
| err_flag | output | 1 | Sticky transfer error |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A descriptor that both asks for an interrupt and fails its transfer makes irq and err_flag change on the same clock edge. Both are driven from the write-back completion. The bench sets that up by having its datapath model return xfer_err for a descriptor with status 0x09. It then expects exactly one irq pulse, a raised err_flag and a written-back status of 0x18. It also shows that the error survives idle time and is removed by the next accepted start.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int FLD_W  = 8;

    // status bit positions
    localparam int S_OWN  = 0;
    localparam int S_WRAP = 1;
    localparam int S_CONT = 2;
    localparam int S_INTR = 3;
    localparam int S_FAIL = 4;
    localparam int S_EXT  = 7;
    // command bit position
    localparam int C_SWAP = 7;

    localparam int DESC_BYTES     = 8;
    localparam int DESC_EXT_BYTES = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_XFER, ST_WB, ST_NEXT
    } seq_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] cmd;
        logic [FLD_W-1:0] stat;
        logic [CNT_W-1:0] count;
    } desc_hdr_t;
endpackage

// File: rtl/bdr_hdr_decode.sv
module bdr_hdr_decode
    import bdr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output desc_hdr_t         hdr_o,
    output logic              own_o
);
    always_comb begin
        hdr_o = desc_hdr_t'(word_i);
        own_o = hdr_o.stat[S_OWN];
    end
endmodule

// File: rtl/bdr_ptr_next.sv
module bdr_ptr_next
    import bdr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic          wrap_i,
    input  logic          ext_i,
    output logic [AW-1:0] next_o
);
    localparam logic [AW-1:0] STEP_N = AW'(DESC_BYTES);
    localparam logic [AW-1:0] STEP_X = AW'(DESC_EXT_BYTES);

    logic [AW-1:0] step;

    always_comb begin
        step   = ext_i ? STEP_X : STEP_N;
        next_o = wrap_i ? base_i : (cur_i + step);
    end
endmodule

// File: rtl/bdr_wb_compose.sv
module bdr_wb_compose
    import bdr_pkg::*;
(
    input  desc_hdr_t         hdr_i,
    input  logic              fail_i,
    output logic [WORD_W-1:0] word_o
);
    desc_hdr_t upd;

    always_comb begin
        upd              = hdr_i;
        upd.stat[S_OWN]  = 1'b0;
        upd.stat[S_FAIL] = hdr_i.stat[S_FAIL] | fail_i;
        word_o           = WORD_W'(upd);
    end
endmodule

// File: rtl/bdring_seq.sv
module bdring_seq
    import bdr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [31:0]       xfer_addr,
    output logic [31:0]       xfer_ext_addr,
    output logic [15:0]       xfer_count,
    output logic [1:0]        xfer_size,
    output logic              xfer_swap,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic [AW-1:0]     cur_ptr,
    output logic              busy,
    output logic              err_flag,
    output logic              irq
);
    localparam logic [AW-1:0] OFS_W1 = AW'(4);
    localparam logic [AW-1:0] OFS_W2 = AW'(8);

    typedef struct packed {
        seq_state_e        state;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     base;
        desc_hdr_t         hdr;
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] ext_addr;
        logic              xfail;
        logic              err;
        logic              irq;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    desc_hdr_t         dec_hdr;
    logic              dec_own;
    logic [AW-1:0]     ptr_nxt;
    logic [WORD_W-1:0] wb_word;

    bdr_hdr_decode u_dec (
        .word_i (mem_rdata),
        .hdr_o  (dec_hdr),
        .own_o  (dec_own)
    );

    bdr_ptr_next #(.AW(AW)) u_ptr (
        .cur_i  (r_q.cur),
        .base_i (r_q.base),
        .wrap_i (r_q.hdr.stat[S_WRAP]),
        .ext_i  (r_q.hdr.stat[S_EXT]),
        .next_o (ptr_nxt)
    );

    bdr_wb_compose u_wb (
        .hdr_i  (r_q.hdr),
        .fail_i (r_q.xfail),
        .word_o (wb_word)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_RD0;
                    r_d.cur   = base_ptr;
                    r_d.base  = base_ptr;
                    r_d.err   = 1'b0;
                end
            end
            ST_RD0: begin
                if (mem_ack) begin
                    r_d.hdr   = dec_hdr;
                    r_d.state = dec_own ? ST_RD1 : ST_IDLE;
                end
            end
            ST_RD1: begin
                if (mem_ack) begin
                    r_d.buf_addr = mem_rdata;
                    r_d.ext_addr = '0;
                    r_d.state    = r_q.hdr.stat[S_EXT] ? ST_RD2 : ST_XFER;
                end
            end
            ST_RD2: begin
                if (mem_ack) begin
                    r_d.ext_addr = mem_rdata;
                    r_d.state    = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    r_d.xfail = xfer_err;
                    r_d.state = ST_WB;
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    r_d.irq   = r_q.hdr.stat[S_INTR];
                    r_d.err   = r_q.err | r_q.xfail;
                    r_d.state = ST_NEXT;
                end
            end
            ST_NEXT: begin
                r_d.cur   = ptr_nxt;
                r_d.state = r_q.hdr.stat[S_CONT] ? ST_RD0 : ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req = (r_q.state == ST_RD0) || (r_q.state == ST_RD1) ||
                  (r_q.state == ST_RD2) || (r_q.state == ST_WB);
        mem_we  = (r_q.state == ST_WB);
        case (r_q.state)
            ST_RD1:  mem_addr = r_q.cur + OFS_W1;
            ST_RD2:  mem_addr = r_q.cur + OFS_W2;
            default: mem_addr = r_q.cur;
        endcase
        mem_wdata     = wb_word;
        xfer_req      = (r_q.state == ST_XFER);
        xfer_addr     = r_q.buf_addr;
        xfer_ext_addr = r_q.ext_addr;
        xfer_count    = r_q.hdr.count;
        xfer_size     = r_q.hdr.cmd[1:0];
        xfer_swap     = r_q.hdr.cmd[C_SWAP];
        cur_ptr       = r_q.cur;
        busy          = (r_q.state != ST_IDLE);
        err_flag      = r_q.err;
        irq           = r_q.irq;
    end
endmodule

// File: rtl/bdr_seq_chk.sv
module bdr_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] base_ptr,
    input logic [AW-1:0] cur_ptr,
    input logic          busy,
    input logic          err_flag,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic          xfer_req,
    input logic [31:0]   xfer_addr,
    input logic [15:0]   xfer_count
);
    // R1
    start_loads_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cur_ptr == $past(base_ptr)));

    // R3
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req)) |-> ($stable(xfer_addr) && $stable(xfer_count)));

    // R3
    xfer_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !mem_req);

    // R5
    wb_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !xfer_req));

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !start) |=> err_flag);
endmodule

bind bdring_seq bdr_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .base_ptr   (base_ptr),
    .cur_ptr    (cur_ptr),
    .busy       (busy),
    .err_flag   (err_flag),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .xfer_req   (xfer_req),
    .xfer_addr  (xfer_addr),
    .xfer_count (xfer_count)
);

// File: tb/sim_bdring_seq.sv
module sim_bdring_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_ptr = '0;
    logic          mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic          xfer_req, xfer_swap, xfer_done = 1'b0, xfer_err = 1'b0;
    logic [31:0]   xfer_addr, xfer_ext_addr;
    logic [15:0]   xfer_count;
    logic [1:0]    xfer_size;
    logic [AW-1:0] cur_ptr;
    logic          busy, err_flag, irq;

    int n_chk = 0, n_fail = 0;
    int irq_cnt = 0, wr_cnt = 0, n_xfer = 0, dly = 0;
    logic inject = 1'b0;

    logic [31:0] mem [0:1023];
    logic [31:0] lg_addr [0:15];
    logic [31:0] lg_ext  [0:15];
    logic [15:0] lg_cnt  [0:15];
    logic [1:0]  lg_size [0:15];
    logic        lg_swap [0:15];

    always #10 clk = ~clk;

    bdring_seq #(.AW(AW)) u0 (.*);

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    // datapath stub: completes after three cycles
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_req && !xfer_done) begin
            if (dly == 2) begin
                xfer_done <= 1'b1;
                xfer_err  <= inject;
                dly = 0;
                lg_addr[n_xfer[3:0]] = xfer_addr;
                lg_ext[n_xfer[3:0]]  = xfer_ext_addr;
                lg_cnt[n_xfer[3:0]]  = xfer_count;
                lg_size[n_xfer[3:0]] = xfer_size;
                lg_swap[n_xfer[3:0]] = xfer_swap;
                n_xfer = n_xfer + 1;
            end else begin
                dly = dly + 1;
            end
        end
    end

    always @(posedge clk) if (irq) irq_cnt = irq_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [15:0] cnt, input logic [7:0] st,
                            input logic [7:0] cmd, input logic [31:0] b, input logic [31:0] x);
        mem[a >> 2] = {cmd, st, cnt};
        mem[(a >> 2) + 1] = b;
        if (st[7]) mem[(a >> 2) + 2] = x;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic go(input logic [AW-1:0] b);
        @(negedge clk);
        base_ptr = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset irq", 32'(irq), 0);
        chk("R9 reset err", 32'(err_flag), 0);
        chk("R1 reset cur_ptr", 32'(cur_ptr), 0);
    endtask

    task automatic t_single();
        int x0 = n_xfer, i0 = irq_cnt;
        put_desc(16'h100, 16'h0040, 8'h09, 8'h01, 32'hA000_0000, 0);
        go(16'h100);
        chk("R3 xfer count", 32'(n_xfer - x0), 1);
        chk("R3 addr", lg_addr[x0[3:0]], 32'hA000_0000);
        chk("R3 ext zero", lg_ext[x0[3:0]], 0);
        chk("R3 cnt", 32'(lg_cnt[x0[3:0]]), 32'h40);
        chk("R3 size 8-bit", 32'(lg_size[x0[3:0]]), 1);
        chk("R3 no swap", 32'(lg_swap[x0[3:0]]), 0);
        chk("R5 writeback", mem[16'h100 >> 2], 32'h0108_0040);
        chk("R6 advance 8", 32'(cur_ptr), 32'h108);
        chk("R8 irq once", 32'(irq_cnt - i0), 1);
        chk("R7 stop busy", 32'(busy), 0);
    endtask

    task automatic t_chain();
        int x0 = n_xfer;
        put_desc(16'h200, 16'h0010, 8'h05, 8'h00, 32'hB0, 0);
        put_desc(16'h208, 16'h0020, 8'h85, 8'h82, 32'hB1, 32'hE1);
        put_desc(16'h214, 16'h0030, 8'h01, 8'h03, 32'hB2, 0);
        go(16'h200);
        chk("R7 chain count", 32'(n_xfer - x0), 3);
        chk("R2 ext addr", lg_ext[(x0 + 1) & 15], 32'hE1);
        chk("R3 size 16", 32'(lg_size[(x0 + 1) & 15]), 2);
        chk("R3 swap", 32'(lg_swap[(x0 + 1) & 15]), 1);
        chk("R2 after ext buf", lg_addr[(x0 + 2) & 15], 32'hB2);
        chk("R3 size 24", 32'(lg_size[(x0 + 2) & 15]), 3);
        chk("R6 ptr 8+12+8", 32'(cur_ptr), 32'h21C);
        chk("R5 wb d1", mem[16'h208 >> 2], 32'h8284_0020);
        chk("R5 ext word kept", mem[16'h210 >> 2], 32'hE1);
        chk("R5 wb d2", mem[16'h214 >> 2], 32'h0300_0030);
    endtask

    task automatic t_wrap();
        int x0 = n_xfer;
        put_desc(16'h300, 16'h0008, 8'h05, 8'h00, 32'hC0, 0);
        put_desc(16'h308, 16'h0008, 8'h07, 8'h00, 32'hC1, 0);
        go(16'h300);
        chk("R6 wrap xfers", 32'(n_xfer - x0), 2);
        chk("R6 wrap to base", 32'(cur_ptr), 32'h300);
        chk("R4 halt on refetch", 32'(busy), 0);
        chk("R5 wb wrap desc", mem[16'h308 >> 2], 32'h0006_0008);
    endtask

    task automatic t_err_irq();
        int i0 = irq_cnt, x0;
        put_desc(16'h400, 16'h0004, 8'h09, 8'h00, 32'hD0, 0);
        inject = 1'b1;
        go(16'h400);
        inject = 1'b0;
        chk("R9 err set", 32'(err_flag), 1);
        chk("R8 irq with error", 32'(irq_cnt - i0), 1);
        chk("R5 fail bit", mem[16'h400 >> 2], 32'h0018_0004);
        repeat (5) @(negedge clk);
        chk("R9 err sticky idle", 32'(err_flag), 1);
        // R10: failed first descriptor, walk still continues
        put_desc(16'h480, 16'h0004, 8'h05, 8'h00, 32'hD1, 0);
        put_desc(16'h488, 16'h0004, 8'h01, 8'h00, 32'hD2, 0);
        x0 = n_xfer;
        inject = 1'b1;
        go(16'h480);
        inject = 1'b0;
        chk("R10 walk continues", 32'(n_xfer - x0), 2);
        chk("R10 ptr", 32'(cur_ptr), 32'h490);
        put_desc(16'h500, 16'h0004, 8'h01, 8'h00, 32'hD3, 0);
        go(16'h500);
        chk("R9 err cleared by start", 32'(err_flag), 0);
    endtask

    task automatic t_busy_start();
        int x0 = n_xfer;
        put_desc(16'h600, 16'h0077, 8'h01, 8'h00, 32'hF0, 0);
        put_desc(16'h700, 16'h0088, 8'h01, 8'h00, 32'hF1, 0);
        @(negedge clk);
        base_ptr = 16'h600;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 100 && !xfer_req; i++) @(negedge clk);
        base_ptr = 16'h700;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk("R1 busy start ignored xfers", 32'(n_xfer - x0), 1);
        chk("R1 busy start cnt", 32'(lg_cnt[x0[3:0]]), 32'h77);
        chk("R1 busy start ptr", 32'(cur_ptr), 32'h608);
        chk("R1 other desc untouched", mem[16'h700 >> 2], 32'h0001_0088);
    endtask

    task automatic t_not_owned();
        int x0 = n_xfer, w0 = wr_cnt, i0 = irq_cnt;
        put_desc(16'h800, 16'h0005, 8'h0C, 8'h00, 32'h11, 0);
        go(16'h800);
        chk("R4 no xfer", 32'(n_xfer - x0), 0);
        chk("R4 no write", 32'(wr_cnt - w0), 0);
        chk("R4 ptr held", 32'(cur_ptr), 32'h800);
        chk("R4 idle", 32'(busy), 0);
        chk("R4 no irq", 32'(irq_cnt - i0), 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_chain();
        t_wrap();
        t_err_irq();
        t_busy_start();
        t_not_owned();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule